// File: doc/BRIEF.md
# Blower Motor Pulse-Width Generator

This block drives a DC blower motor with a pulse-width modulated output that software controls over a small register bus. Software sets the length of one pulse period in clock cycles, the number of cycles at the start of each period during which the output is held low, and an on/off bit. While the generator runs, a counter steps through each period, and the output is low for the programmed low time and high for the remainder of the period.

The low-time register has a hardware floor. A programmed low time that is too short would give a stalled motor pulses it cannot turn with, which only heat it, so a write below the floor is raised to just above it before it is stored. Period and low-time writes reach the running waveform only at a period boundary, so a period is never cut short. Turning the generator off parks the counter at zero and holds the output low. It restarts only when the on/off bit goes from 0 to 1.

Top module: `pwm_blower_top`

## Requirements
- R1: After reset, the period register reads 0, the low-time register reads MIN_LOW+1 and the on/off register reads 0. The output is 0.
- R2: While running, the counter takes the values 1, 2, ..., P and then returns to 1, so one output period lasts exactly P cycles.
- R3: While running, the output is 0 when the count is less than or equal to the active low time L, and 1 when the count is greater than L. Each period is therefore L cycles low followed by P-L cycles high.
- R4: While the on/off bit is 0, the counter is held at 0 and the output is 0.
- R5: A run starts with count 1 in the second cycle after a write of 1 to the on/off bit (bit 0 of the write data), provided that bit was 0 before the write. Writing 1 while the bit is already 1 does not restart the period.
- R6: A low-time write with a value below MIN_LOW stores MIN_LOW+1 instead. A value of MIN_LOW or above is stored unchanged.
- R7: A stored period of 0 or 1 runs as a period of 2.
- R8: New period and low-time values take effect only when a period ends, or when a run starts.
- R9: A read at offset 0 returns the period, offset 1 returns the stored (floored) low time, offset 2 returns the on/off bit in bit 0, and offset 3 returns 0. The read data is combinational from the offset.
- R10: When L is greater than or equal to the period, the output stays 0 for the whole period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 2 | Word offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| pwm_out | output | 1 | Pulse-width modulated motor drive |

## Verification
Two events can fall on the same cycle: a bus write that changes the period or low time, and the period wrap that loads the shadow copies. The bench writes new values at many points within a period, including the cycles next to the wrap, so some writes land right on the boundary. A per-cycle reference model decides on its own whether the old or the new value governs each period, and the bench compares the output against it. A write of 1 to an on/off bit that is already 1, made in the middle of a period, is judged the same way: the waveform must continue with no restart.

// File: rtl/pwm_blower_pkg.sv
package pwm_blower_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_PERIOD = 2'd0,
        REG_LOW    = 2'd1,
        REG_ONOFF  = 2'd2
    } reg_sel_e;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_blower_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int MIN_LOW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] per_o,
    output logic [DATA_W-1:0] low_o,
    output logic              en_o,
    output logic [DATA_W-1:0] rdata_o
);
    localparam logic [DATA_W-1:0] MIN_W   = DATA_W'(MIN_LOW);
    localparam logic [DATA_W-1:0] FLOOR_W = DATA_W'(MIN_LOW + 1);

    typedef struct packed {
        logic [DATA_W-1:0] per;
        logic [DATA_W-1:0] low;
        logic              en;
    } regs_t;

    regs_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_i) begin
            case (reg_sel_e'(addr_i))
                REG_PERIOD: s_d.per = wdata_i;
                REG_LOW:    s_d.low = (wdata_i < MIN_W) ? FLOOR_W : wdata_i;
                REG_ONOFF:  s_d.en  = wdata_i[0];
                default:    s_d     = s_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.per <= '0;
            s_q.low <= FLOOR_W;
            s_q.en  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        case (reg_sel_e'(addr_i))
            REG_PERIOD: rdata_o = s_q.per;
            REG_LOW:    rdata_o = s_q.low;
            REG_ONOFF:  rdata_o = {{(DATA_W-1){1'b0}}, s_q.en};
            default:    rdata_o = '0;
        endcase
    end

    assign per_o = s_q.per;
    assign low_o = s_q.low;
    assign en_o  = s_q.en;

    // R6: a write below the floor is stored as floor+1
    a_r6_floor_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == REG_LOW && wdata_i < MIN_W) |=> (low_o == FLOOR_W));

    // R9: the on/off register takes bit 0 of the write data
    a_r9_onoff_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == REG_ONOFF) |=> (en_o == $past(wdata_i[0])));
endmodule

// File: rtl/pwm_core.sv
module pwm_core #(
    parameter int DATA_W  = 32,
    parameter int MIN_LOW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [DATA_W-1:0] per_i,
    input  logic [DATA_W-1:0] low_i,
    output logic              pwm_o
);
    localparam logic [DATA_W-1:0] PER_MIN = DATA_W'(2);
    localparam logic [DATA_W-1:0] FLOOR_W = DATA_W'(MIN_LOW + 1);

    typedef struct packed {
        logic              run;
        logic [DATA_W-1:0] cnt;
        logic [DATA_W-1:0] aper;
        logic [DATA_W-1:0] alow;
        logic              out;
    } core_t;

    core_t s_d, s_q;
    logic [DATA_W-1:0] eff_per;

    always_comb begin
        eff_per = (per_i < PER_MIN) ? PER_MIN : per_i;
        s_d     = s_q;
        s_d.run = en_i;
        if (!en_i) begin
            s_d.cnt = '0;
        end else if (!s_q.run || s_q.cnt == s_q.aper) begin
            s_d.cnt  = DATA_W'(1);
            s_d.aper = eff_per;
            s_d.alow = low_i;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
        s_d.out = en_i && (s_d.cnt > s_d.alow);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.run  <= 1'b0;
            s_q.cnt  <= '0;
            s_q.aper <= PER_MIN;
            s_q.alow <= FLOOR_W;
            s_q.out  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pwm_o = s_q.out;

    // R4: disabled means counter parked and output low
    a_r4_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (s_q.cnt == '0 && !pwm_o));

    // R2: at the period end the count returns to 1
    a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && s_q.run && s_q.cnt == s_q.aper) |=> (s_q.cnt == DATA_W'(1)));

    // R8: the shadow copies hold inside a running period
    a_r8_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && s_q.run && s_q.cnt != s_q.aper)
        |=> ($stable(s_q.aper) && $stable(s_q.alow)));

    // R3: the low phase keeps the output at 0
    a_r3_low_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cnt != '0 && s_q.cnt <= s_q.alow) |-> !pwm_o);

    // R7: the active period is never below 2
    a_r7_period_floor: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.aper >= PER_MIN);
endmodule

// File: rtl/pwm_blower_top.sv
module pwm_blower_top
    import pwm_blower_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int MIN_LOW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              pwm_out
);
    logic [DATA_W-1:0] per_w;
    logic [DATA_W-1:0] low_w;
    logic              en_w;

    pwm_regs #(.DATA_W(DATA_W), .MIN_LOW(MIN_LOW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (bus_wr),
        .addr_i  (bus_addr),
        .wdata_i (bus_wdata),
        .per_o   (per_w),
        .low_o   (low_w),
        .en_o    (en_w),
        .rdata_o (bus_rdata)
    );

    pwm_core #(.DATA_W(DATA_W), .MIN_LOW(MIN_LOW)) u_core (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (en_w),
        .per_i (per_w),
        .low_i (low_w),
        .pwm_o (pwm_out)
    );
endmodule

// File: tb/tb_pwm_blower_top.sv
module tb_pwm_blower_top;
    localparam int DW  = 32;
    localparam int MIN = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [1:0]    bus_addr = 2'd0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          pwm_out;

    int    checks = 0;
    int    errors = 0;
    string phase = "R1 reset state";

    always #4 clk = ~clk;

    pwm_blower_top #(.DATA_W(DW), .MIN_LOW(MIN)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    // behavioural reference: register view and waveform
    longint m_per, m_low, m_en, m_run, m_cnt, m_aper, m_alow, m_out, eff;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_per = 0; m_low = MIN + 1; m_en = 0; m_run = 0;
            m_cnt = 0; m_aper = 2; m_alow = MIN + 1; m_out = 0;
        end else begin
            eff = (m_per < 2) ? 2 : m_per;
            if (m_en == 0) m_cnt = 0;
            else if (m_run == 0 || m_cnt == m_aper) begin
                m_cnt = 1; m_aper = eff; m_alow = m_low;
            end else m_cnt = m_cnt + 1;
            m_run = m_en;
            m_out = (m_en != 0 && m_cnt > m_alow) ? 1 : 0;
            if (bus_wr) begin
                if (bus_addr == 2'd0) m_per = bus_wdata;
                else if (bus_addr == 2'd1) m_low = (bus_wdata < MIN) ? MIN + 1 : bus_wdata;
                else if (bus_addr == 2'd2) m_en = bus_wdata[0];
            end
        end
    end

    function automatic longint model_rd(input logic [1:0] a);
        case (a)
            2'd0: return m_per;
            2'd1: return m_low;
            2'd2: return m_en;
            default: return 0;
        endcase
    endfunction

    // compared every cycle, away from both clock edges
    always @(posedge clk) begin
        #3;
        if (rst_n) begin
            checks++;
            if (longint'(pwm_out) != m_out) begin
                errors++;
                $display("FAIL %s pwm_out actual %0b expected %0d", phase, pwm_out, m_out);
            end
            checks++;
            if (longint'(bus_rdata) != model_rd(bus_addr)) begin
                errors++;
                $display("FAIL %s rdata[%0d] actual %0d expected %0d",
                         phase, bus_addr, bus_rdata, model_rd(bus_addr));
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic idle(input int n, input logic [1:0] a);
        @(negedge clk);
        bus_addr = a;
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_rd(input logic [1:0] a, input longint exp, input string tag);
        @(negedge clk);
        bus_addr = a;
        #1;
        checks++;
        if (longint'(bus_rdata) != exp) begin
            errors++;
            $display("FAIL %s readback[%0d] actual %0d expected %0d", tag, a, bus_rdata, exp);
        end
    endtask

    task automatic finish_run;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        phase = "R1 reset state";
        expect_rd(2'd0, 0, "R1 period");
        expect_rd(2'd1, MIN + 1, "R1 low");
        expect_rd(2'd2, 0, "R1 onoff");
        checks++;
        if (pwm_out !== 1'b0) begin
            errors++;
            $display("FAIL R1 pwm_out actual %0b expected 0", pwm_out);
        end

        phase = "R2 R3 R5 basic run";
        wr(2'd0, 10);
        wr(2'd1, 6);
        wr(2'd2, 1);
        idle(35, 2'd2);

        phase = "R6 floor clamp and R8 update at wrap";
        wr(2'd1, 2);
        expect_rd(2'd1, MIN + 1, "R6 clamped low");
        idle(25, 2'd1);
        wr(2'd1, MIN);
        expect_rd(2'd1, MIN, "R6 low at floor kept");
        idle(3, 2'd1);

        phase = "R8 writes near the boundary";
        for (int k = 0; k < 12; k++) begin
            wr(2'd0, 8 + (k % 5));
            wr(2'd1, 5 + (k % 4));
            idle(k % 3, 2'd0);
        end
        idle(30, 2'd0);

        phase = "R5 re-enable while running";
        wr(2'd2, 1);
        idle(20, 2'd2);

        phase = "R7 R10 period floor";
        wr(2'd0, 1);
        idle(12, 2'd0);
        wr(2'd0, 0);
        idle(12, 2'd0);
        wr(2'd1, 1);
        idle(12, 2'd1);

        phase = "R10 low beyond period";
        wr(2'd0, 7);
        wr(2'd1, 9);
        idle(20, 2'd1);

        phase = "R4 disabled";
        wr(2'd2, 0);
        idle(15, 2'd2);
        wr(2'd0, 6);
        wr(2'd1, 4);
        idle(10, 2'd3);
        expect_rd(2'd3, 0, "R9 unused offset");
        expect_rd(2'd0, 6, "R9 period offset");
        expect_rd(2'd2, 0, "R9 onoff offset");

        phase = "R5 restart after clear";
        wr(2'd2, 1);
        expect_rd(2'd2, 1, "R9 onoff set");
        idle(25, 2'd1);
        wr(2'd2, 32'h2);
        idle(8, 2'd2);

        finish_run();
    end
endmodule